// File: doc/BRIEF.md
# Sector-Erasable Serial Flash Model

This block is a synthesizable behavioural model of a small user flash array: 512 words of 16 bits in two sectors of 256 words. All access goes through two serial registers. A 9-bit address register is filled MSB first through its own shift clock, shift enable and data input. A 16-bit data register is filled or emptied MSB first through a second shift clock, enable, input and output. Level strobes request a read, a program or a sector erase. A busy output covers each program and erase operation.

Flash rules apply throughout. Erase sets every word of the selected sector to all ones. Programming can only clear bits, so the stored word becomes the old word ANDed with the data register. Each word may be programmed at most twice between erases. Misuse is reported on two sticky error outputs. The serial clocks and strobes are plain inputs sampled by the system clock, and each acts on its rising edge as seen by that clock. The serial clocks must therefore toggle slower than half the system clock.

Top module: `sector_flash_model`

## Requirements
- R1: On each rising edge of `addr_clk` seen while `addr_shift_en` is high and `busy` is low, the address register shifts left by one and takes `addr_din` into bit 0, so nine shifts load an address MSB first.
- R2: `data_dout` always shows bit 15 of the data register. A rising edge of `data_clk` while `data_shift_en` is high shifts that register left and takes `data_din` into bit 0.
- R3: A rising edge of `read_strobe` while `busy` is low loads the word at the current address into the data register on the same clock edge that sees the strobe.
- R4: A rising edge of `prog_strobe` while `busy` is low stores (old word AND data register) at the current address. `busy` then stays high for exactly PROG_CYCLES clock cycles, starting on the edge that sees the strobe.
- R5: A rising edge of `erase_strobe` while `busy` is low erases the sector selected by address bit 8 (0 selects words 0–255, 1 selects words 256–511). Every word of that sector then reads 0xFFFF, and the other sector is left unchanged. `busy` stays high for exactly ERASE_CYCLES cycles, and ERASE_CYCLES must be at least 256.
- R6: Rising edges of any strobe that occur while `busy` is high are ignored. They do not lengthen `busy`, do not load the data register and do not change the array.
- R7: An address shift request (a rising edge of `addr_clk` with `addr_shift_en` high) that arrives while `busy` is high leaves the address register unchanged and sets `addr_err`. `addr_err` stays set until reset.
- R8: A program request is rejected in two cases: the word has already been programmed twice since its last erase, or it has been programmed once and the data register has a 1 where the stored word has a 0. A rejected request leaves the word and its write count unchanged, sets `prog_err` until reset, and still runs `busy` for PROG_CYCLES.
- R9: After a synchronous active-low reset, `busy`, `addr_err`, `prog_err` and `data_dout` are 0. The array contents are kept across reset.
- R10: When strobes rise on the same cycle, erase takes priority over program, and program takes priority over read. Only the winning command runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_clk | input | 1 | Address register shift clock |
| addr_shift_en | input | 1 | Address shift enable |
| addr_din | input | 1 | Address serial input |
| data_clk | input | 1 | Data register shift clock |
| data_shift_en | input | 1 | Data shift enable |
| data_din | input | 1 | Data serial input |
| data_dout | output | 1 | Data serial output (bit 15 of the data register) |
| erase_strobe | input | 1 | Sector erase request (rising edge) |
| prog_strobe | input | 1 | Program request (rising edge) |
| read_strobe | input | 1 | Read request (rising edge) |
| busy | output | 1 | Program or erase in progress |
| addr_err | output | 1 | Sticky: address shift attempted while busy |
| prog_err | output | 1 | Sticky: overprogram request rejected |

## Verification
The hardest case to reach from the ports is a command or address shift that arrives inside a busy window. Showing that it was ignored needs the array or a register to hold a value that the ignored action would visibly change. For the busy-window strobes, the bench preloads the data register with a known pattern, starts an erase, and fires program, read and erase strobes while `busy` is high. It then checks that the busy window did not lengthen, that the pattern shifts out intact, and that the target word is still 0xFFFF. For the address case, it shifts address bits during a short program window. A following read then returns the programmed word and not the erased word at the shifted address.

// File: rtl/ufm_pkg.sv
// Shared definitions for the sector flash model.
// Assumes a 9-bit word address whose MSB selects one of two sectors.
package ufm_pkg;
    localparam int ADDR_W = 9;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2
    } op_state_t;
endpackage

// File: rtl/ufm_edge.sv
// Rising-edge detector for a vector of inputs that are synchronous to clk.
// Assumes the inputs are already in the clk domain. rise is combinational on the current input.
module ufm_edge #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_in,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev;

    // remember last sampled level of every input
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= sig_in;
    end

    assign rise = sig_in & ~prev;
endmodule

// File: rtl/ufm_shreg.sv
// Left-shifting serial register with optional parallel load.
// Assumes load and shift are never needed together; load wins if both occur.
module ufm_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         sin,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] q
);
    // parallel load or MSB-first serial shift
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (load_en)  q <= load_val;
        else if (shift_en) q <= {q[W-2:0], sin};
    end
endmodule

// File: rtl/ufm_ctrl.sv
// Operation sequencer: holds busy for a fixed cycle count per operation and
// walks one word per cycle through a sector during erase.
// Assumes ERASE_CYCLES >= SECT_WORDS and both cycle counts >= 1.
module ufm_ctrl
    import ufm_pkg::*;
#(
    parameter int ERASE_CYCLES = 320,
    parameter int PROG_CYCLES  = 8,
    parameter int SECT_WORDS   = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_erase,
    input  logic                          start_prog,
    output logic                          busy,
    output logic                          erase_we,
    output logic [$clog2(SECT_WORDS)-1:0] erase_idx
);
    localparam int MAXC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam int SW   = $clog2(SECT_WORDS);
    localparam logic [CW-1:0] E_LAST = CW'(ERASE_CYCLES - 1);
    localparam logic [CW-1:0] P_LAST = CW'(PROG_CYCLES - 1);
    localparam logic [CW-1:0] S_END  = CW'(SECT_WORDS);

    op_state_t       state;
    logic [CW-1:0]   cnt;
    logic            at_end;

    assign at_end = (state == ST_ERASE) ? (cnt == E_LAST) : (cnt == P_LAST);

    // start an operation when idle, count its cycles, return to idle at the end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (state == ST_IDLE) begin
            cnt <= '0;
            if (start_erase)     state <= ST_ERASE;
            else if (start_prog) state <= ST_PROG;
        end else if (at_end) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign busy      = (state != ST_IDLE);
    assign erase_we  = (state == ST_ERASE) && (cnt < S_END);
    assign erase_idx = cnt[SW-1:0];
endmodule

// File: rtl/ufm_array.sv
// Word array with a per-word program counter, one write port and an asynchronous read.
// Assumes the caller merges program data and chooses between erase and program writes.
module ufm_array #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  rd_cnt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CNT_W-1:0]  wr_cnt
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem  [DEPTH];
    logic [CNT_W-1:0]  wcnt [DEPTH];

    // single write port for word and its program count
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr]  <= wr_data;
            wcnt[wr_addr] <= wr_cnt;
        end
    end

    assign rd_data = mem[rd_addr];
    assign rd_cnt  = wcnt[rd_addr];
endmodule

// File: rtl/sector_flash_model.sv
// Top of the sector flash model: serial address and data registers, command
// decode with erase > program > read priority, flash AND-programming with
// overprogram guard, and sticky error flags.
// Assumes all serial clocks and strobes are synchronous to clk and slower than clk/2.
module sector_flash_model
    import ufm_pkg::*;
#(
    parameter int ERASE_CYCLES = 320,
    parameter int PROG_CYCLES  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic addr_clk,
    input  logic addr_shift_en,
    input  logic addr_din,
    input  logic data_clk,
    input  logic data_shift_en,
    input  logic data_din,
    output logic data_dout,
    input  logic erase_strobe,
    input  logic prog_strobe,
    input  logic read_strobe,
    output logic busy,
    output logic addr_err,
    output logic prog_err
);
    localparam int SECT_WORDS = 1 << (ADDR_W - 1);
    localparam int SW         = ADDR_W - 1;

    logic [4:0]        rise;
    logic              addr_rise, data_rise, erase_rise, prog_rise, read_rise;
    logic              cmd_erase, cmd_prog, cmd_read, prog_bad, addr_req;
    logic [ADDR_W-1:0] areg, wr_addr;
    logic [DATA_W-1:0] dreg, rd_data, wr_data;
    logic [CNT_W-1:0]  rd_cnt, wr_cnt;
    logic              erase_we, wr_en;
    logic [SW-1:0]     erase_idx;

    ufm_edge #(.N(5)) u_edge (
        .clk(clk), .rst_n(rst_n),
        .sig_in({addr_clk, data_clk, erase_strobe, prog_strobe, read_strobe}),
        .rise(rise)
    );
    assign {addr_rise, data_rise, erase_rise, prog_rise, read_rise} = rise;

    assign cmd_erase = erase_rise && !busy;
    assign cmd_prog  = prog_rise && !busy && !erase_rise;
    assign cmd_read  = read_rise && !busy && !erase_rise && !prog_rise;
    assign addr_req  = addr_rise && addr_shift_en;

    ufm_shreg #(.W(ADDR_W)) u_areg (
        .clk(clk), .rst_n(rst_n),
        .shift_en(addr_req && !busy), .sin(addr_din),
        .load_en(1'b0), .load_val('0), .q(areg)
    );

    ufm_shreg #(.W(DATA_W)) u_dreg (
        .clk(clk), .rst_n(rst_n),
        .shift_en(data_rise && data_shift_en), .sin(data_din),
        .load_en(cmd_read), .load_val(rd_data), .q(dreg)
    );
    assign data_dout = dreg[DATA_W-1];

    ufm_ctrl #(
        .ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES), .SECT_WORDS(SECT_WORDS)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start_erase(cmd_erase), .start_prog(cmd_prog),
        .busy(busy), .erase_we(erase_we), .erase_idx(erase_idx)
    );

    // third attempt, or second attempt that needs a 0 -> 1 change
    assign prog_bad = (rd_cnt >= 2'd2) ||
                      ((rd_cnt == 2'd1) && |(dreg & ~rd_data));

    // select the single array write: erase walk, else accepted program
    always_comb begin
        wr_en   = 1'b0;
        wr_addr = areg;
        wr_data = rd_data & dreg;
        wr_cnt  = rd_cnt + 1'b1;
        if (erase_we) begin
            wr_en   = 1'b1;
            wr_addr = {areg[ADDR_W-1], erase_idx};
            wr_data = '1;
            wr_cnt  = '0;
        end else if (cmd_prog && !prog_bad) begin
            wr_en = 1'b1;
        end
    end

    ufm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_array (
        .clk(clk), .rd_addr(areg), .rd_data(rd_data), .rd_cnt(rd_cnt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_cnt(wr_cnt)
    );

    // sticky error flags, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_err <= 1'b0;
            prog_err <= 1'b0;
        end else begin
            if (addr_req && busy)     addr_err <= 1'b1;
            if (cmd_prog && prog_bad) prog_err <= 1'b1;
        end
    end
endmodule

// File: rtl/ufm_checker.sv
// Property checker for sector_flash_model, attached by bind.
// Assumes the bound signal names of the top module.
module ufm_checker #(
    parameter int ERASE_CYCLES = 320,
    parameter int PROG_CYCLES  = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        addr_err,
    input logic        prog_err,
    input logic        cmd_read,
    input logic [8:0]  areg,
    input logic [15:0] dreg,
    input logic [15:0] rd_data
);
    int run;

    // length of the current busy window
    always_ff @(posedge clk) begin
        if (!rst_n)    run <= 0;
        else if (busy) run <= run + 1;
        else           run <= 0;
    end

    a_r7_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(areg));
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |=> addr_err);
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        prog_err |=> prog_err);
    a_r3_read_loads: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_read |=> dreg == $past(rd_data));
    a_r4_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run == PROG_CYCLES || run == ERASE_CYCLES));
endmodule

bind sector_flash_model ufm_checker #(
    .ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .addr_err(addr_err),
    .prog_err(prog_err), .cmd_read(cmd_read), .areg(areg),
    .dreg(dreg), .rd_data(rd_data)
);

// File: tb/sector_flash_model_tb.sv
module sector_flash_model_tb;
    localparam int EC = 260;
    localparam int PC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_clk = 0, addr_shift_en = 0, addr_din = 0;
    logic data_clk = 0, data_shift_en = 0, data_din = 0;
    logic erase_strobe = 0, prog_strobe = 0, read_strobe = 0;
    logic data_dout, busy, addr_err, prog_err;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    sector_flash_model #(.ERASE_CYCLES(EC), .PROG_CYCLES(PC)) u_dut (.*);

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic shift_addr(input logic [8:0] a);
        addr_shift_en = 1;
        for (int i = 8; i >= 0; i--) begin
            @(negedge clk); addr_din = a[i]; addr_clk = 1;
            @(negedge clk); addr_clk = 0;
        end
        addr_shift_en = 0;
    endtask

    task automatic shift_data(input logic [15:0] d);
        data_shift_en = 1;
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk); data_din = d[i]; data_clk = 1;
            @(negedge clk); data_clk = 0;
        end
        data_shift_en = 0;
    endtask

    // shift the data register out MSB first; ends at a negedge
    task automatic dump_data(output logic [15:0] v);
        data_shift_en = 1; data_din = 0;
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk); v[i] = data_dout; data_clk = 1;
            @(negedge clk); data_clk = 0;
        end
        data_shift_en = 0;
    endtask

    // raise the chosen strobes {erase,prog,read}, return busy window length
    task automatic strobe(input logic [2:0] s, output int len);
        @(negedge clk);
        {erase_strobe, prog_strobe, read_strobe} = s;
        @(negedge clk);
        {erase_strobe, prog_strobe, read_strobe} = 3'b000;
        len = busy ? 1 : 0;
        while (busy) begin
            @(negedge clk);
            if (busy) len++;
        end
    endtask

    task automatic read_word(input logic [8:0] a, output logic [15:0] v);
        int n;
        shift_addr(a);
        strobe(3'b001, n);
        dump_data(v);
    endtask

    task automatic prog_word(input logic [8:0] a, input logic [15:0] d, output int len);
        shift_addr(a);
        shift_data(d);
        strobe(3'b010, len);
    endtask

    task automatic t_reset();
        do_reset();
        check(busy == 0 && addr_err == 0 && prog_err == 0 && data_dout == 0, "R9 reset outputs",
              {busy, addr_err, prog_err, data_dout}, 0);
    endtask

    task automatic t_erase_both();
        int n; logic [15:0] v;
        shift_addr(9'h000); strobe(3'b100, n);
        check(n == EC, "R5 erase busy length s0", n, EC);
        shift_addr(9'h100); strobe(3'b100, n);
        check(n == EC, "R5 erase busy length s1", n, EC);
        read_word(9'h000, v); check(v == 16'hFFFF, "R5 s0 first word", v, 16'hFFFF);
        read_word(9'h0FF, v); check(v == 16'hFFFF, "R5 s0 last word", v, 16'hFFFF);
        read_word(9'h1FF, v); check(v == 16'hFFFF, "R5 s1 last word", v, 16'hFFFF);
    endtask

    task automatic t_program_and();
        int n; logic [15:0] v;
        prog_word(9'h0A5, 16'h1234, n);
        check(n == PC, "R4 program busy length", n, PC);
        read_word(9'h0A5, v); check(v == 16'h1234, "R1 R2 R3 R4 first program", v, 16'h1234);
        prog_word(9'h0A5, 16'h1030, n);
        read_word(9'h0A5, v); check(v == 16'h1030, "R4 second program AND", v, 16'h1030);
        check(prog_err == 0, "R8 legal second program", prog_err, 0);
    endtask

    task automatic t_overprog();
        int n; logic [15:0] v;
        prog_word(9'h0A5, 16'h0000, n);
        check(prog_err == 1, "R8 third program flagged", prog_err, 1);
        check(n == PC, "R8 rejected program busy length", n, PC);
        read_word(9'h0A5, v); check(v == 16'h1030, "R8 third program no write", v, 16'h1030);
        do_reset();
        check(prog_err == 0, "R9 error cleared by reset", prog_err, 0);
        read_word(9'h0A5, v); check(v == 16'h1030, "R9 array kept over reset", v, 16'h1030);
        prog_word(9'h0B0, 16'h00FF, n);
        prog_word(9'h0B0, 16'h0F0F, n);
        check(prog_err == 1, "R8 zero-to-one second program flagged", prog_err, 1);
        read_word(9'h0B0, v); check(v == 16'h00FF, "R8 zero-to-one no write", v, 16'h00FF);
        do_reset();
    endtask

    task automatic t_addr_busy();
        int n; logic [15:0] v;
        shift_addr(9'h0C0); shift_data(16'h00F0);
        @(negedge clk); prog_strobe = 1;
        @(negedge clk); prog_strobe = 0;
        addr_shift_en = 1; addr_din = 1;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); addr_clk = 1;
            @(negedge clk); addr_clk = 0;
        end
        addr_shift_en = 0;
        while (busy) @(negedge clk);
        check(addr_err == 1, "R7 shift during busy flagged", addr_err, 1);
        strobe(3'b001, n); dump_data(v);
        check(v == 16'h00F0, "R7 address held during busy", v, 16'h00F0);
        do_reset();
    endtask

    task automatic t_busy_ignore();
        int n; logic [15:0] v;
        shift_addr(9'h100); shift_data(16'hABCD);
        @(negedge clk); erase_strobe = 1;
        @(negedge clk); erase_strobe = 0; n = 1;
        repeat (4) @(negedge clk);
        prog_strobe = 1; @(negedge clk); prog_strobe = 0;
        read_strobe = 1; @(negedge clk); read_strobe = 0;
        erase_strobe = 1; @(negedge clk); erase_strobe = 0;
        n = 8;
        while (busy) begin @(negedge clk); if (busy) n++; end
        check(n == EC, "R6 busy not extended", n, EC);
        dump_data(v); check(v == 16'hABCD, "R6 read ignored while busy", v, 16'hABCD);
        read_word(9'h100, v); check(v == 16'hFFFF, "R6 program ignored while busy", v, 16'hFFFF);
        read_word(9'h0A5, v); check(v == 16'h1030, "R5 other sector untouched", v, 16'h1030);
    endtask

    task automatic t_priority();
        int n; logic [15:0] v;
        prog_word(9'h1A0, 16'h0000, n);
        shift_data(16'h0000);
        strobe(3'b110, n);
        check(n == EC, "R10 erase beats program length", n, EC);
        read_word(9'h1A0, v); check(v == 16'hFFFF, "R10 erase beats program data", v, 16'hFFFF);
        shift_data(16'h5A5A);
        strobe(3'b011, n);
        check(n == PC, "R10 program beats read length", n, PC);
        dump_data(v); check(v == 16'h5A5A, "R10 read not run with program", v, 16'h5A5A);
    endtask

    initial begin
        t_reset();
        t_erase_both();
        t_program_and();
        t_overprog();
        t_addr_busy();
        t_busy_ignore();
        t_priority();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule